// File: doc/BRIEF.md
# Fixed-Point Adder/Subtractor with Configurable Latency

This block sums or differences two fixed-point operands. Each operand has its own total width, fractional bit count and signedness. The operation is fixed when the block is built, either add or subtract, or it is picked every cycle by a one-bit select input. A carry-in input may be enabled. It adds one unit at the finest fractional position.

Before the add, the block brings both operands onto a common binary point. It extends them to an internal width that cannot overflow. The result then leaves the block in one of two forms:

- an exact full-precision word, or
- a narrower word with its own width, fraction and signedness. This word is shaped by a chosen rounding rule and a chosen overflow rule.

A carry-out can be taken when the output is an unsigned word whose integer part is exactly as wide as the wider input integer part.

The result is delayed by a set number of cycles. A valid flag travels with it. The delay can sit entirely at the output, or up to two of its stages can be moved inside the datapath. The total delay stays the same either way.

Top module: `fixed_addsub`

## Requirements
- R1: With the operation chosen at run time, sub=1 gives a minus b and sub=0 gives a plus b.
- R2: With the operation fixed at build time, the sub input has no effect on the result.
- R3: When enabled, cin=1 adds exactly one unit of the finer of the two operand fractions to the exact result.
- R4: The operand with fewer fractional bits is shifted left until both binary points line up before the add.
- R5: In full-precision mode the output is a signed word of max(integer bits)+max(fraction bits)+2 bits. Its binary point sits at max(fraction bits), and it equals the exact result.
- R6: In round mode, dropped fractional bits round the result to the nearest output step, with exact halves moving away from zero (for example, -1.5 steps becomes -2).
- R7: In saturate mode, a result above the output maximum gives the maximum, and one below the output minimum gives the minimum. For a signed 6-bit output these are 31 and -32 steps (bit pattern 6'h20).
- R8: In wrap mode the output keeps only its low Y_W bits. When enabled, cout is bit Y_W of the result expressed at the output fraction.
- R9: A result and its out_valid appear exactly LATENCY cycles after the in_valid cycle that carried the operands, for both placements of the delay.
- R10: Reset clears every pipeline stage, so out_valid is 0 in the cycle after any reset cycle.
- R11: A cycle with in_valid=0 never produces an out_valid=1 cycle, whatever the operand values are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on a, b, sub, cin are valid this cycle |
| a | input | A_W | First operand, A_FRAC fraction bits |
| b | input | B_W | Second operand, B_FRAC fraction bits |
| sub | input | 1 | 1 selects a minus b when the operation is chosen at run time |
| cin | input | 1 | Carry-in, used only when HAS_CIN is set |
| out_valid | output | 1 | Result on y is valid |
| y | output | OUT_W | Result: IW bits in full-precision mode, else Y_W bits |
| cout | output | 1 | Carry-out, 0 unless enabled and legal |

## Verification
Any fault in alignment, operand inversion or carry handling is visible at y as a wrong value. It appears exactly LATENCY cycles after the offending input, because every stage is a plain register. A fault in the rounding bias or the saturation limits shows only on operands near half-steps or near the format edges. The bench therefore aims directed vectors at those points.

A lost or extra valid bit in the delay stages shows as a result arriving in the wrong cycle, or as an output with no matching input. The cycle stamp on each expected item catches it on the first affected result.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_DYN = 2'd2
    } op_mode_e;

    typedef enum logic {
        Q_TRUNC = 1'b0,
        Q_ROUND = 1'b1
    } quant_e;

    typedef enum logic {
        O_WRAP = 1'b0,
        O_SAT  = 1'b1
    } ovf_e;

    function automatic int imax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    function automatic int imin(input int x, input int y);
        return (x < y) ? x : y;
    endfunction

endpackage

// File: rtl/addsub_align.sv
module addsub_align
    import addsub_pkg::*;
#(
    parameter int       A_W      = 8,
    parameter int       A_FRAC   = 4,
    parameter bit       A_SIGNED = 1'b1,
    parameter int       B_W      = 6,
    parameter int       B_FRAC   = 2,
    parameter bit       B_SIGNED = 1'b1,
    parameter int       FRAC     = 4,
    parameter int       IW       = 10,
    parameter op_mode_e OP_MODE  = OP_DYN,
    parameter bit       HAS_CIN  = 1'b1
) (
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    input  logic           sub,
    input  logic           cin,
    output logic [IW-1:0]  a_x,
    output logic [IW-1:0]  b_x,
    output logic [1:0]     carry
);
    localparam int A_SH = FRAC - A_FRAC;
    localparam int B_SH = FRAC - B_FRAC;

    logic [IW-1:0] a_ext, b_ext, b_al;
    logic          do_sub, cin_eff;

    // extend to the internal width, then move onto the common binary point
    assign a_ext = {{(IW-A_W){A_SIGNED & a[A_W-1]}}, a};
    assign b_ext = {{(IW-B_W){B_SIGNED & b[B_W-1]}}, b};
    assign a_x   = a_ext << A_SH;
    assign b_al  = b_ext << B_SH;

    generate
        if (OP_MODE == OP_DYN) begin : g_dyn
            assign do_sub = sub;
        end else begin : g_fix
            assign do_sub = (OP_MODE == OP_SUB);
        end
        if (HAS_CIN) begin : g_cin
            assign cin_eff = cin;
        end else begin : g_nocin
            assign cin_eff = 1'b0;
        end
    endgenerate

    // subtraction as inverted b plus one; carry-in stacks on top
    assign b_x   = do_sub ? ~b_al : b_al;
    assign carry = {1'b0, do_sub} + {1'b0, cin_eff};

endmodule

// File: rtl/addsub_delay.sv
module addsub_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         i_vld,
    input  logic [W-1:0] i_dat,
    output logic         o_vld,
    output logic [W-1:0] o_dat
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign o_vld = i_vld;
            assign o_dat = i_dat;
        end else begin : g_pipe
            logic [DEPTH-1:0]        vld_q;
            logic [DEPTH-1:0][W-1:0] dat_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q <= '0;
                    dat_q <= '0;
                end else begin
                    vld_q[0] <= i_vld;
                    dat_q[0] <= i_dat;
                    for (int k = 1; k < DEPTH; k++) begin
                        vld_q[k] <= vld_q[k-1];
                        dat_q[k] <= dat_q[k-1];
                    end
                end
            end

            assign o_vld = vld_q[DEPTH-1];
            assign o_dat = dat_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/addsub_quant.sv
module addsub_quant
    import addsub_pkg::*;
#(
    parameter int     IW        = 10,
    parameter int     FRAC      = 4,
    parameter bit     FULL_PREC = 1'b0,
    parameter int     Y_W       = 6,
    parameter int     Y_FRAC    = 2,
    parameter bit     Y_SIGNED  = 1'b1,
    parameter quant_e QUANT     = Q_ROUND,
    parameter ovf_e   OVF       = O_SAT,
    parameter bit     COUT_EN   = 1'b0,
    parameter int     OUT_W     = 6
) (
    input  logic [IW-1:0]    sum,
    output logic [OUT_W-1:0] y,
    output logic             cout
);
    localparam int UP = (Y_FRAC > FRAC) ? Y_FRAC - FRAC : 0;
    localparam int DN = (FRAC > Y_FRAC) ? FRAC - Y_FRAC : 0;
    localparam int QW = IW + UP + 1;

    generate
        if (FULL_PREC) begin : g_full
            assign y    = sum;
            assign cout = 1'b0;
        end else begin : g_red
            localparam logic signed [QW-1:0] HI = Y_SIGNED ? (QW'(1) << (Y_W-1)) - QW'(1)
                                                           : (QW'(1) << Y_W) - QW'(1);
            localparam logic signed [QW-1:0] LO = Y_SIGNED ? -(QW'(1) << (Y_W-1)) : '0;

            logic signed [QW-1:0] ext, q, sat;

            assign ext = {{(UP+1){sum[IW-1]}}, sum} << UP;

            if (DN == 0) begin : g_keep
                assign q = ext;
            end else if (QUANT == Q_ROUND) begin : g_round
                localparam logic signed [QW-1:0] HALF = QW'(1) << (DN-1);
                logic signed [QW-1:0] bias;
                // negative values take one less bias so ties move away from zero
                assign bias = ext[QW-1] ? HALF - QW'(1) : HALF;
                assign q    = (ext + bias) >>> DN;
            end else begin : g_trunc
                assign q = ext >>> DN;
            end

            assign sat = (q > HI) ? HI : ((q < LO) ? LO : q);

            if (OVF == O_SAT) begin : g_sat
                assign y = sat[Y_W-1:0];
            end else begin : g_wrap
                assign y = q[Y_W-1:0];
            end

            if (COUT_EN) begin : g_cout
                assign cout = q[Y_W];
            end else begin : g_nocout
                assign cout = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/fixed_addsub.sv
module fixed_addsub
    import addsub_pkg::*;
#(
    parameter int       A_W       = 8,
    parameter int       A_FRAC    = 4,
    parameter bit       A_SIGNED  = 1'b1,
    parameter int       B_W       = 6,
    parameter int       B_FRAC    = 2,
    parameter bit       B_SIGNED  = 1'b1,
    parameter op_mode_e OP_MODE   = OP_DYN,
    parameter bit       HAS_CIN   = 1'b1,
    parameter bit       HAS_COUT  = 1'b0,
    parameter bit       FULL_PREC = 1'b0,
    parameter int       Y_W       = 6,
    parameter int       Y_FRAC    = 2,
    parameter bit       Y_SIGNED  = 1'b1,
    parameter quant_e   QUANT     = Q_ROUND,
    parameter ovf_e     OVF       = O_SAT,
    parameter int       LATENCY   = 3,
    parameter bit       SPREAD    = 1'b1,
    localparam int      FRAC      = imax(A_FRAC, B_FRAC),
    localparam int      INTB      = imax(A_W - A_FRAC, B_W - B_FRAC),
    localparam int      IW        = INTB + FRAC + 2,
    localparam int      OUT_W     = FULL_PREC ? IW : Y_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [A_W-1:0]   a,
    input  logic [B_W-1:0]   b,
    input  logic             sub,
    input  logic             cin,
    output logic             out_valid,
    output logic [OUT_W-1:0] y,
    output logic             cout
);
    localparam int  NIN     = SPREAD ? imin(LATENCY, 2) : 0;
    localparam int  NOUT    = LATENCY - NIN;
    localparam bit  COUT_OK = !FULL_PREC && !A_SIGNED && !B_SIGNED && !Y_SIGNED
                              && ((Y_W - Y_FRAC) == INTB);
    localparam bit  COUT_EN = HAS_COUT && COUT_OK;
    localparam int  W1      = 2*IW + 2;
    localparam int  W3      = OUT_W + 1;

    logic [IW-1:0] al_a, al_b, s1_a, s1_b, sum0, s2_sum;
    logic [1:0]    al_c, s1_c;
    logic [W1-1:0] s1_dat;
    logic          s1_vld, s2_vld, q_cout;
    logic [OUT_W-1:0] q_y;
    logic [W3-1:0] o_dat;

    addsub_align #(
        .A_W(A_W), .A_FRAC(A_FRAC), .A_SIGNED(A_SIGNED),
        .B_W(B_W), .B_FRAC(B_FRAC), .B_SIGNED(B_SIGNED),
        .FRAC(FRAC), .IW(IW), .OP_MODE(OP_MODE), .HAS_CIN(HAS_CIN)
    ) u_align (
        .a(a), .b(b), .sub(sub), .cin(cin),
        .a_x(al_a), .b_x(al_b), .carry(al_c)
    );

    // first inner boundary: after alignment
    addsub_delay #(.W(W1), .DEPTH((NIN >= 1) ? 1 : 0)) u_d_align (
        .clk(clk), .rst(rst), .i_vld(in_valid), .i_dat({al_a, al_b, al_c}),
        .o_vld(s1_vld), .o_dat(s1_dat)
    );

    assign {s1_a, s1_b, s1_c} = s1_dat;
    assign sum0 = s1_a + s1_b + IW'(s1_c);

    // second inner boundary: after the adder
    addsub_delay #(.W(IW), .DEPTH((NIN >= 2) ? 1 : 0)) u_d_sum (
        .clk(clk), .rst(rst), .i_vld(s1_vld), .i_dat(sum0),
        .o_vld(s2_vld), .o_dat(s2_sum)
    );

    addsub_quant #(
        .IW(IW), .FRAC(FRAC), .FULL_PREC(FULL_PREC), .Y_W(Y_W), .Y_FRAC(Y_FRAC),
        .Y_SIGNED(Y_SIGNED), .QUANT(QUANT), .OVF(OVF), .COUT_EN(COUT_EN), .OUT_W(OUT_W)
    ) u_quant (
        .sum(s2_sum), .y(q_y), .cout(q_cout)
    );

    // remaining latency as an output shift register
    addsub_delay #(.W(W3), .DEPTH(NOUT)) u_d_out (
        .clk(clk), .rst(rst), .i_vld(s2_vld), .i_dat({q_cout, q_y}),
        .o_vld(out_valid), .o_dat(o_dat)
    );

    assign {cout, y} = o_dat;

endmodule

// File: rtl/fixed_addsub_chk.sv
module fixed_addsub_chk #(
    parameter int LATENCY = 3,
    parameter int OUT_W   = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] y
);
    localparam logic [15:0] LAT16 = 16'(LATENCY);

    logic [15:0] inflight;

    always_ff @(posedge clk) begin
        if (rst) inflight <= '0;
        else     inflight <= inflight + 16'(in_valid) - 16'(out_valid);
    end

    // R9: never more results in flight than stages
    assert_inflight_bound_R9: assert property (@(posedge clk) disable iff (rst)
        inflight <= LAT16);

    // R9: a valid result is fully defined
    assert_known_result_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$isunknown(y));

    // R11: no output without an accepted input
    assert_no_phantom_R11: assert property (@(posedge clk) disable iff (rst)
        (inflight == 16'd0 && !(LATENCY == 0 && in_valid)) |-> !out_valid);

    // R10: reset empties the pipeline
    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (LATENCY > 0 && $past(rst)) |-> !out_valid);

endmodule

bind fixed_addsub fixed_addsub_chk #(.LATENCY(LATENCY), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid), .y(y)
);

// File: tb/tb_fixed_addsub.sv
module tb_fixed_addsub;
    import addsub_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    int   cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic       v_in = 1'b0;
    logic [7:0] a0 = '0;
    logic [5:0] b0 = '0;
    logic       sub0 = 1'b0, cin0 = 1'b0;
    logic [7:0] a1 = '0, b1 = '0;
    logic [5:0] a2 = '0;
    logic [4:0] b2 = '0;
    logic       sub2 = 1'b0;

    logic [5:0] y0;
    logic [7:0] y1;
    logic [9:0] y2;
    logic       v0, v1, v2, c0, c1, c2;

    // signed dynamic, rounding, saturating, delay spread inside
    fixed_addsub #(
        .A_W(8), .A_FRAC(4), .A_SIGNED(1'b1), .B_W(6), .B_FRAC(2), .B_SIGNED(1'b1),
        .OP_MODE(OP_DYN), .HAS_CIN(1'b1), .HAS_COUT(1'b0), .FULL_PREC(1'b0),
        .Y_W(6), .Y_FRAC(2), .Y_SIGNED(1'b1), .QUANT(Q_ROUND), .OVF(O_SAT),
        .LATENCY(3), .SPREAD(1'b1)
    ) dut (
        .clk(clk), .rst(rst), .in_valid(v_in), .a(a0), .b(b0), .sub(sub0), .cin(cin0),
        .out_valid(v0), .y(y0), .cout(c0)
    );

    // unsigned add, wrap, carry-out, delay at output
    fixed_addsub #(
        .A_W(8), .A_FRAC(1), .A_SIGNED(1'b0), .B_W(8), .B_FRAC(1), .B_SIGNED(1'b0),
        .OP_MODE(OP_ADD), .HAS_CIN(1'b0), .HAS_COUT(1'b1), .FULL_PREC(1'b0),
        .Y_W(8), .Y_FRAC(1), .Y_SIGNED(1'b0), .QUANT(Q_TRUNC), .OVF(O_WRAP),
        .LATENCY(2), .SPREAD(1'b0)
    ) dut_u (
        .clk(clk), .rst(rst), .in_valid(v_in), .a(a1), .b(b1), .sub(1'b0), .cin(1'b0),
        .out_valid(v1), .y(y1), .cout(c1)
    );

    // fixed subtract, full precision, mixed signedness
    fixed_addsub #(
        .A_W(6), .A_FRAC(3), .A_SIGNED(1'b1), .B_W(5), .B_FRAC(0), .B_SIGNED(1'b0),
        .OP_MODE(OP_SUB), .HAS_CIN(1'b0), .HAS_COUT(1'b0), .FULL_PREC(1'b1),
        .Y_W(8), .Y_FRAC(0), .Y_SIGNED(1'b1), .QUANT(Q_TRUNC), .OVF(O_WRAP),
        .LATENCY(1), .SPREAD(1'b1)
    ) dut_f (
        .clk(clk), .rst(rst), .in_valid(v_in), .a(a2), .b(b2), .sub(sub2), .cin(1'b0),
        .out_valid(v2), .y(y2), .cout(c2)
    );

    typedef struct {
        logic [15:0] y;
        logic        c;
        int          due;
        string       tag;
    } exp_t;

    exp_t q0[$], q1[$], q2[$];
    int   n_chk = 0, n_fail = 0;
    bit   finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic longint round_away(input longint x, input int d);
        longint p, h;
        p = longint'(1) <<< d;
        h = p >>> 1;
        if (x >= 0) return (x + h) / p;
        return -((-x + h) / p);
    endfunction

    task automatic drive(input string tag, input bit vld,
                         input logic [7:0] xa0, input logic [5:0] xb0,
                         input bit xs0, input bit xc0,
                         input logic [7:0] xa1, input logic [7:0] xb1,
                         input logic [5:0] xa2, input logic [4:0] xb2, input bit xs2);
        exp_t   e;
        longint ex, qv;
        @(posedge clk);
        #2;
        v_in = vld; a0 = xa0; b0 = xb0; sub0 = xs0; cin0 = xc0;
        a1 = xa1; b1 = xb1; a2 = xa2; b2 = xb2; sub2 = xs2;
        if (vld) begin
            // b0 has 2 fraction bits, a0 has 4: scale b0 by 4
            ex = longint'($signed(xa0));
            if (xs0) ex = ex - longint'($signed(xb0)) * 4;
            else     ex = ex + longint'($signed(xb0)) * 4;
            ex = ex + longint'(xc0);
            qv = round_away(ex, 2);
            if (qv > 31)  qv = 31;
            if (qv < -32) qv = -32;
            e.y = '0; e.y[5:0] = qv[5:0]; e.c = 1'b0; e.due = cyc + 3; e.tag = tag;
            q0.push_back(e);

            ex = longint'(xa1) + longint'(xb1);
            e.y = '0; e.y[7:0] = ex[7:0]; e.c = ex[8]; e.due = cyc + 2; e.tag = "R8";
            q1.push_back(e);

            ex = longint'($signed(xa2)) - longint'(xb2) * 8;
            e.y = '0; e.y[9:0] = ex[9:0]; e.c = 1'b0; e.due = cyc + 1; e.tag = "R2 R5";
            q2.push_back(e);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (!rst && !finished) begin
            if (v0) begin
                if (q0.size() == 0) chk(1'b0, "R11", "dut unexpected output", 1, 0);
                else begin
                    e = q0.pop_front();
                    chk(y0 == e.y[5:0], e.tag, "dut y", longint'($signed(y0)), longint'($signed(e.y[5:0])));
                    chk(cyc == e.due, "R9", "dut cycle", cyc, e.due);
                end
            end
            if (v1) begin
                if (q1.size() == 0) chk(1'b0, "R11", "dut_u unexpected output", 1, 0);
                else begin
                    e = q1.pop_front();
                    chk(y1 == e.y[7:0], e.tag, "dut_u y", longint'(y1), longint'(e.y[7:0]));
                    chk(c1 == e.c, "R8", "dut_u cout", longint'(c1), longint'(e.c));
                    chk(cyc == e.due, "R9", "dut_u cycle", cyc, e.due);
                end
            end
            if (v2) begin
                if (q2.size() == 0) chk(1'b0, "R11", "dut_f unexpected output", 1, 0);
                else begin
                    e = q2.pop_front();
                    chk(y2 == e.y[9:0], e.tag, "dut_f y", longint'($signed(y2)), longint'($signed(e.y[9:0])));
                    chk(cyc == e.due, "R9", "dut_f cycle", cyc, e.due);
                end
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!v0 && !v1 && !v2, "R10", "valid during reset", longint'({v0, v1, v2}), 0);
        @(posedge clk);
        #2 rst = 1'b0;

        drive("R1", 1, 8'h18, 6'h06, 0, 0, 8'h03, 8'h04, 6'h08, 5'd1, 0);   // 1.5+1.5=3.0
        drive("R1", 1, 8'h18, 6'h06, 1, 0, 8'hFF, 8'h01, 6'h08, 5'd1, 1);   // 1.5-1.5=0
        drive("R3", 1, 8'h01, 6'h00, 0, 1, 8'h80, 8'h80, 6'h3F, 5'd31, 0);  // 2/16 rounds to 1 step
        drive("R6", 1, 8'hFA, 6'h00, 0, 0, 8'hFF, 8'hFF, 6'h20, 5'd0, 1);   // -1.5 steps -> -2
        drive("R6", 1, 8'h06, 6'h00, 0, 0, 8'h00, 8'h00, 6'h1F, 5'd0, 0);   // +1.5 steps -> +2
        drive("R4", 1, 8'h00, 6'h01, 0, 0, 8'h7F, 8'h01, 6'h00, 5'd16, 1);  // b LSB = 4 a LSBs
        drive("R7", 1, 8'h7F, 6'h1F, 0, 0, 8'h10, 8'h20, 6'h01, 5'd2, 0);   // saturate high 31
        drive("R7", 1, 8'h80, 6'h1F, 1, 0, 8'h01, 8'h02, 6'h02, 5'd3, 1);   // saturate low -32
        drive("R11", 0, 8'h7F, 6'h1F, 1, 1, 8'hFF, 8'hFF, 6'h3F, 5'd31, 1); // bubble
        drive("R11", 0, 8'h55, 6'h2A, 0, 1, 8'hAA, 8'h55, 6'h15, 5'd9, 0);  // bubble
        drive("R1", 1, 8'hF0, 6'h3C, 1, 1, 8'h40, 8'hC0, 6'h10, 5'd5, 1);

        for (int i = 0; i < 400; i++) begin
            drive("R1", ($urandom % 4) != 0, 8'($urandom), 6'($urandom), 1'($urandom),
                  1'($urandom), 8'($urandom), 8'($urandom), 6'($urandom), 5'($urandom),
                  1'($urandom));
        end
        repeat (6) drive("R11", 0, 8'h00, 6'h00, 0, 0, 8'h00, 8'h00, 6'h00, 5'd0, 0);
        chk(q0.size() == 0 && q1.size() == 0 && q2.size() == 0, "R9", "results pending",
            longint'(q0.size() + q1.size() + q2.size()), 0);

        // reset with results in flight
        drive("R10", 1, 8'h10, 6'h04, 0, 0, 8'h01, 8'h01, 6'h01, 5'd1, 0);
        drive("R10", 1, 8'h20, 6'h08, 0, 0, 8'h02, 8'h02, 6'h02, 5'd2, 0);
        @(posedge clk);
        #2;
        rst = 1'b1;
        v_in = 1'b0;
        q0.delete(); q1.delete(); q2.delete();
        @(posedge clk);
        @(negedge clk);
        chk(!v0 && !v1 && !v2, "R10", "valid after reset", longint'({v0, v1, v2}), 0);
        @(posedge clk);
        #2 rst = 1'b0;
        repeat (5) drive("R11", 0, 8'hFF, 6'h3F, 1, 1, 8'hFF, 8'hFF, 6'h3F, 5'd31, 1);
        drive("R1", 1, 8'h08, 6'h02, 0, 0, 8'h05, 8'h06, 6'h04, 5'd1, 1);
        repeat (5) drive("R11", 0, 8'h00, 6'h00, 0, 0, 8'h00, 8'h00, 6'h00, 5'd0, 0);
        chk(q0.size() == 0 && q1.size() == 0 && q2.size() == 0, "R9", "results pending",
            longint'(q0.size() + q1.size() + q2.size()), 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule